// File: doc/BRIEF.md
# Detector readout word-stream decoder

This block sits on a stream of 32-bit readout words coming out of a front-end digitiser. It takes one word per cycle through a ready/valid input. It sorts each word by the 4-bit type code in its top nibble and turns the stream into decoded records. A record carries a kind, a channel, a mode, a 32-bit value and a 21-bit fine time. Error and status pulses are raised alongside the records. Downstream logic consumes the records without needing to know how the words were split.

The decoder keeps state across words. It follows event framing from a header word to a trailer word. At the trailer it checks the event number and the number of words in between. It joins the two 16-bit halves of per-channel hit counters, and it treats one reserved counter channel code as the time of the last burst. It also joins the trigger and sample timestamp words into one value. For time measurements it can widen the time by two extra fine bits. Error words are reduced to a masked flag vector plus a priority error signal.

Every output is registered. A record appears in the cycle after its word was accepted. The input is ready whenever reset is low.

Top module: `rostream_decoder`

## Requirements
- R1: While `rst` is high, `in_ready` is low and every output is zero. Reset also forgets every stored counter half, every pending timestamp and any open event.
- R2: A word that produces a record raises `out_valid` only in the cycle after it was accepted. A cycle with no accepted word leaves `out_valid` low in the next cycle.
- R3: Type 2 (header) gives kind 1 and type 3 (trailer) gives kind 2. In both cases `out_value` holds word bits 23:0: the 12-bit event number in 23:12, and in 11:0 either the coarse timestamp (header) or the word count (trailer).
- R4: `out_frame_err` pulses, together with the header or trailer record, in any of these cases: a trailer arrives with no open event; a trailer's event number differs from the open header's; a trailer's count differs from the number of words accepted strictly between header and trailer; a header arrives while an event is open. A header that is not preceded by an open event gives no pulse.
- R5: In counter words, bits 27:19 are a 9-bit channel field and bits 15:0 are the payload. A type 0 word stores the high half for slot (field & 0x1F). A following type 1 word for the same slot gives kind 3, channel = field & 0x1F and value {high, low}.
- R6: A counter channel field of 0x1FF uses its own slot, separate from channel 31. It gives kind 4 (burst time) with channel 0 and value {high, low}.
- R7: A type 1 word whose slot holds no stored high half pulses `out_orphan` and gives no record. Each stored high half pairs at most once.
- R8: In data words (types 4 and 5), bits 27:26 are the mode, 25:24 the two extra fine bits, 23:19 the channel and 18:0 the data. Mode 0 gives kind 5 with value = data. `out_time` is the data zero-extended when `fine_mode` is low, and {data, fine bits} when it is high.
- R9: A type 5 word in mode 1 or 2 gives kind 6 with value = data bits 15:0, ignoring bits 18:16. Mode 3 gives kind 7 with all 19 data bits.
- R10: A type 4 word with nonzero mode and bit 16 = 0 stores a 16-bit trigger stamp for its channel and gives no record. A following one with bit 16 = 1 on the same channel gives kind 8 with value {trigger, sample stamp} and the word's mode. Without a matching pending stamp it pulses `out_orphan` and gives no record.
- R11: Any accepted type 4 or 5 word whose channel is 16 or higher pulses `out_chan_err` in the next cycle. The word is still decoded normally.
- R12: Type 6 gives kind 9 with `out_err_flags` = word bits 14:0 and bit 14 forced to zero. `out_prio_err` is high exactly when bit 12 or bit 13 is set.
- R13: Type 7 and any other unused code give no record. They still count as words inside an open event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fine_mode | input | 1 | Append the two extra fine bits to time measurements |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Decoder accepts a word (low only during reset) |
| in_word | input | 32 | Readout word |
| out_valid | output | 1 | Decoded record present |
| out_kind | output | 4 | Record kind (1 header … 9 error, 0 idle) |
| out_chan | output | 5 | Record channel |
| out_mode | output | 2 | Mode field of data and timestamp records |
| out_value | output | 32 | Record value |
| out_time | output | 21 | Time of a mode 0 record |
| out_chan_err | output | 1 | Reserved data channel seen |
| out_err_flags | output | 15 | Masked error flags of an error word |
| out_prio_err | output | 1 | Event-size or trigger-overflow error |
| out_frame_err | output | 1 | Header/trailer consistency error |
| out_orphan | output | 1 | Unpaired second word dropped |

## Verification
Two functions can land in the same output cycle. A framing error arrives together with the header or trailer record that exposed it, and a reserved-channel flag arrives together with the decoded data record of the same word. The bench provokes the first by sending a header while an event is open, and a trailer with a wrong count or a wrong event number. It provokes the second by sweeping all 32 data channels in both time-word types and both fine settings. Each sample then checks the record fields and the flag together, against values the bench computes from the word it sent.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  // word type codes in bits 31:28
  localparam logic [3:0] T_CNT_HI = 4'd0;
  localparam logic [3:0] T_CNT_LO = 4'd1;
  localparam logic [3:0] T_HEADER = 4'd2;
  localparam logic [3:0] T_TRAILR = 4'd3;
  localparam logic [3:0] T_DATA_A = 4'd4;
  localparam logic [3:0] T_DATA_B = 4'd5;
  localparam logic [3:0] T_ERRWRD = 4'd6;

  // record kinds on out_kind
  localparam logic [3:0] K_NONE    = 4'd0;
  localparam logic [3:0] K_HEADER  = 4'd1;
  localparam logic [3:0] K_TRAILER = 4'd2;
  localparam logic [3:0] K_COUNT   = 4'd3;
  localparam logic [3:0] K_BURST   = 4'd4;
  localparam logic [3:0] K_TIME    = 4'd5;
  localparam logic [3:0] K_SAMPLE  = 4'd6;
  localparam logic [3:0] K_SUM     = 4'd7;
  localparam logic [3:0] K_TSTAMP  = 4'd8;
  localparam logic [3:0] K_ERROR   = 4'd9;
endpackage

// File: rtl/rsd_frame_track.sv
module rsd_frame_track #(
  parameter int EVN_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             is_hdr,
  input  logic             is_trl,
  input  logic [EVN_W-1:0] evn,
  input  logic [CNT_W-1:0] tail,
  output logic             frame_err
);
  logic             open_q;
  logic [EVN_W-1:0] evn_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      evn_q     <= '0;
      cnt_q     <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (acc) begin
        if (is_hdr) begin
          frame_err <= open_q;
          open_q    <= 1'b1;
          evn_q     <= evn;
          cnt_q     <= '0;
        end else if (is_trl) begin
          frame_err <= !open_q || (evn != evn_q) || (tail != cnt_q);
          open_q    <= 1'b0;
          cnt_q     <= '0;
        end else if (open_q) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_TRAILER_ALONE: assert property (@(posedge clk) disable iff (rst) (acc && is_trl && !open_q) |=> frame_err); // R4
  AST_HEADER_CLEAN: assert property (@(posedge clk) disable iff (rst) (acc && is_hdr && !open_q) |=> !frame_err); // R4
endmodule

// File: rtl/rsd_cnt_pair.sv
module rsd_cnt_pair #(
  parameter int N_CH  = 32,
  parameter int HALF_W = 16,
  localparam int SLOTS = N_CH + 1,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic [IDX_W-1:0]  slot,
  input  logic [HALF_W-1:0] hi_in,
  output logic              hit,
  output logic [HALF_W-1:0] hi_out
);
  logic [HALF_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0]  vld_q;

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_hi) mem[slot] <= hi_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_hi) begin
      vld_q[slot] <= 1'b1;
    end else if (rd_lo && vld_q[slot]) begin
      vld_q[slot] <= 1'b0;
    end
  end

  assign hit    = vld_q[slot];
  assign hi_out = mem[slot];

  AST_LOW_CONSUMES: assert property (@(posedge clk) disable iff (rst) (rd_lo && hit) |=> !vld_q[$past(slot)]); // R7
  AST_HIGH_ARMS: assert property (@(posedge clk) disable iff (rst) wr_hi |=> vld_q[$past(slot)]); // R5
endmodule

// File: rtl/rsd_ts_pair.sv
module rsd_ts_pair #(
  parameter int CH_W   = 5,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr1,
  input  logic              rd2,
  input  logic [CH_W-1:0]   chan,
  input  logic [HALF_W-1:0] trig_in,
  output logic              hit,
  output logic [HALF_W-1:0] trig_out
);
  logic            pend_q;
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      ch_q     <= '0;
      trig_out <= '0;
    end else if (wr1) begin
      pend_q   <= 1'b1;
      ch_q     <= chan;
      trig_out <= trig_in;
    end else if (rd2 && hit) begin
      pend_q <= 1'b0;
    end
  end

  assign hit = pend_q && (ch_q == chan);

  AST_STAMP_CONSUMED: assert property (@(posedge clk) disable iff (rst) (rd2 && hit && !wr1) |=> !pend_q); // R10
endmodule

// File: rtl/rostream_decoder.sv
module rostream_decoder
  import rsd_pkg::*;
#(
  parameter int N_CNT_CH  = 32,
  parameter int N_DATA_CH = 16,
  parameter int EVN_W     = 12,
  parameter int DATA_W    = 19,
  parameter int SAMPLE_W  = 16,
  parameter int TIME_W    = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fine_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              out_valid,
  output logic [3:0]        out_kind,
  output logic [4:0]        out_chan,
  output logic [1:0]        out_mode,
  output logic [31:0]       out_value,
  output logic [TIME_W-1:0] out_time,
  output logic              out_chan_err,
  output logic [14:0]       out_err_flags,
  output logic              out_prio_err,
  output logic              out_frame_err,
  output logic              out_orphan
);
  localparam int CH_W  = $clog2(N_CNT_CH);
  localparam int IDX_W = $clog2(N_CNT_CH + 1);
  localparam int CNT_W = 24 - EVN_W;

  // field split
  logic                acc;
  logic [3:0]          typ;
  logic [1:0]          mode;
  logic [1:0]          fine;
  logic [4:0]          dch;
  logic [DATA_W-1:0]   data;
  logic [8:0]          cch;
  logic [SAMPLE_W-1:0] half;
  logic                tsel;
  logic                is_burst;
  logic                is_stamp;
  logic [IDX_W-1:0]    slot;

  assign in_ready = !rst;
  assign acc      = in_valid && in_ready;
  assign typ      = in_word[31:28];
  assign mode     = in_word[27:26];
  assign fine     = in_word[25:24];
  assign dch      = in_word[23:19];
  assign data     = in_word[DATA_W-1:0];
  assign cch      = in_word[27:19];
  assign half     = in_word[SAMPLE_W-1:0];
  assign tsel     = in_word[16];
  assign is_burst = (cch == 9'h1FF);
  assign is_stamp = (typ == T_DATA_A) && (mode != 2'd0);
  assign slot     = is_burst ? IDX_W'(N_CNT_CH) : IDX_W'(cch[CH_W-1:0]);

  logic                cp_hit;
  logic [SAMPLE_W-1:0] cp_hi;
  logic                ts_hit;
  logic [SAMPLE_W-1:0] ts_trig;

  rsd_cnt_pair #(.N_CH(N_CNT_CH), .HALF_W(SAMPLE_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .wr_hi  (acc && (typ == T_CNT_HI)),
    .rd_lo  (acc && (typ == T_CNT_LO)),
    .slot   (slot),
    .hi_in  (half),
    .hit    (cp_hit),
    .hi_out (cp_hi)
  );

  rsd_ts_pair #(.CH_W(5), .HALF_W(SAMPLE_W)) u_ts (
    .clk      (clk),
    .rst      (rst),
    .wr1      (acc && is_stamp && !tsel),
    .rd2      (acc && is_stamp && tsel),
    .chan     (dch),
    .trig_in  (half),
    .hit      (ts_hit),
    .trig_out (ts_trig)
  );

  rsd_frame_track #(.EVN_W(EVN_W), .CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .is_hdr    (typ == T_HEADER),
    .is_trl    (typ == T_TRAILR),
    .evn       (in_word[23:24-EVN_W]),
    .tail      (in_word[CNT_W-1:0]),
    .frame_err (out_frame_err)
  );

  // next-record logic
  logic              nv;
  logic [3:0]        nk;
  logic [4:0]        nch;
  logic [1:0]        nmode;
  logic [31:0]       nval;
  logic [TIME_W-1:0] ntime;
  logic              ncherr;
  logic [14:0]       nflags;
  logic              nprio;
  logic              norph;

  always_comb begin
    nv     = 1'b0;
    nk     = K_NONE;
    nch    = '0;
    nmode  = '0;
    nval   = '0;
    ntime  = '0;
    ncherr = 1'b0;
    nflags = '0;
    nprio  = 1'b0;
    norph  = 1'b0;
    if (acc) begin
      case (typ)
        T_CNT_LO: begin
          if (cp_hit) begin
            nv   = 1'b1;
            nk   = is_burst ? K_BURST : K_COUNT;
            nch  = is_burst ? 5'd0 : 5'(cch[CH_W-1:0]);
            nval = {cp_hi, half};
          end else begin
            norph = 1'b1;
          end
        end
        T_HEADER: begin
          nv   = 1'b1;
          nk   = K_HEADER;
          nval = 32'(in_word[23:0]);
        end
        T_TRAILR: begin
          nv   = 1'b1;
          nk   = K_TRAILER;
          nval = 32'(in_word[23:0]);
        end
        T_DATA_A, T_DATA_B: begin
          ncherr = (32'(dch) >= N_DATA_CH);
          nch    = dch;
          nmode  = mode;
          if (mode == 2'd0) begin
            nv    = 1'b1;
            nk    = K_TIME;
            nval  = 32'(data);
            ntime = fine_mode ? {data, fine} : TIME_W'(data);
          end else if (typ == T_DATA_A) begin
            if (tsel) begin
              if (ts_hit) begin
                nv   = 1'b1;
                nk   = K_TSTAMP;
                nval = {ts_trig, half};
              end else begin
                norph = 1'b1;
              end
            end
          end else if (mode == 2'd3) begin
            nv   = 1'b1;
            nk   = K_SUM;
            nval = 32'(data);
          end else begin
            nv   = 1'b1;
            nk   = K_SAMPLE;
            nval = 32'(half);
          end
        end
        T_ERRWRD: begin
          nv     = 1'b1;
          nk     = K_ERROR;
          nflags = in_word[14:0] & 15'h3FFF;
          nprio  = in_word[12] | in_word[13];
        end
        default: ;
      endcase
    end
    if (!nv) begin
      nch   = '0;
      nmode = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_kind      <= K_NONE;
      out_chan      <= '0;
      out_mode      <= '0;
      out_value     <= '0;
      out_time      <= '0;
      out_chan_err  <= 1'b0;
      out_err_flags <= '0;
      out_prio_err  <= 1'b0;
      out_orphan    <= 1'b0;
    end else begin
      out_valid     <= nv;
      out_kind      <= nk;
      out_chan      <= nch;
      out_mode      <= nmode;
      out_value     <= nval;
      out_time      <= ntime;
      out_chan_err  <= ncherr;
      out_err_flags <= nflags;
      out_prio_err  <= nprio;
      out_orphan    <= norph;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !(in_valid && in_ready) |=> !out_valid); // R2
  AST_ORPHAN_DROPS: assert property (@(posedge clk) disable iff (rst) out_orphan |-> !out_valid); // R7
  AST_PRIO_ON_ERR: assert property (@(posedge clk) disable iff (rst) out_prio_err |-> (out_valid && out_kind == K_ERROR)); // R12
  AST_SAMPLE_NARROW: assert property (@(posedge clk) disable iff (rst) (out_valid && out_kind == K_SAMPLE) |-> (out_value[31:16] == 16'd0)); // R9
endmodule

// File: tb/rostream_decoder_test.sv
module rostream_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fine_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [3:0]  out_kind;
  logic [4:0]  out_chan;
  logic [1:0]  out_mode;
  logic [31:0] out_value;
  logic [20:0] out_time;
  logic        out_chan_err;
  logic [14:0] out_err_flags;
  logic        out_prio_err;
  logic        out_frame_err;
  logic        out_orphan;

  int nchk = 0;
  int nerr = 0;
  int nw   = 0;
  bit done = 0;

  rostream_decoder uut (
    .clk(clk), .rst(rst), .fine_mode(fine_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_kind(out_kind), .out_chan(out_chan),
    .out_mode(out_mode), .out_value(out_value), .out_time(out_time), .out_chan_err(out_chan_err),
    .out_err_flags(out_err_flags), .out_prio_err(out_prio_err), .out_frame_err(out_frame_err),
    .out_orphan(out_orphan)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    nw++;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] w_cnt(input logic [3:0] t, input logic [8:0] c, input logic [15:0] v);
    return {t, c, 3'b000, v};
  endfunction
  function automatic logic [31:0] w_ht(input logic [3:0] t, input logic [11:0] e, input logic [11:0] l);
    return {t, 4'h0, e, l};
  endfunction
  function automatic logic [31:0] w_dat(input logic [3:0] t, input logic [1:0] m, input logic [1:0] f,
                                        input logic [4:0] c, input logic [18:0] d);
    return {t, m, f, c, d};
  endfunction
  function automatic logic [31:0] w_ts(input logic [1:0] m, input logic [4:0] c, input logic s, input logic [15:0] v);
    return {4'd4, m, 2'b00, c, 2'b00, s, v};
  endfunction

  task automatic rec(input string req, input logic [3:0] k, input logic [4:0] c, input logic [31:0] v);
    check(req, {out_valid, out_kind, out_chan, out_value}, {1'b1, k, c, v});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {in_ready, out_valid, out_frame_err, out_orphan, out_chan_err}, 0);
    rst = 1'b0;
    idle();
    check("R1 ready after reset", in_ready, 1);
    check("R2 idle no record", out_valid, 0);

    // R3 header, then counter sweep inside the event
    push(w_ht(4'd2, 12'h5A3, 12'h123));
    rec("R3 header", 4'd1, 5'd0, 32'h005A3123);
    check("R4 clean header", out_frame_err, 0);
    nw = 0;
    idle();
    check("R2 one cycle only", out_valid, 0);

    for (int ch = 0; ch < 32; ch++) begin
      logic [15:0] hi;
      logic [15:0] lo;
      hi = 16'(ch * 16'h0111 + 7);
      lo = ~16'(ch * 3);
      push(w_cnt(4'd0, 9'(ch + 32 * (ch % 8)), hi));
      check("R5 high alone no record", out_valid, 0);
      push(w_cnt(4'd1, 9'(ch + 32 * ((ch + 3) % 8)), lo));
      rec("R5 counter pair", 4'd3, 5'(ch), {hi, lo});
    end
    push(w_cnt(4'd1, 9'd5, 16'h1111));
    check("R7 second low orphan", {out_orphan, out_valid}, 2'b10);

    // R6 burst slot distinct from channel 31
    push(w_cnt(4'd0, 9'd31, 16'hAAAA));
    push(w_cnt(4'd0, 9'h1FF, 16'hBBBB));
    push(w_cnt(4'd1, 9'h1FF, 16'h0001));
    rec("R6 burst time", 4'd4, 5'd0, 32'hBBBB0001);
    push(w_cnt(4'd1, 9'h03F, 16'h0002));
    rec("R6 ch31 untouched by burst", 4'd3, 5'd31, 32'hAAAA0002);

    // R13 unused type counts but no record
    push(32'h7123_4567);
    check("R13 type7 no record", {out_valid, out_orphan}, 0);

    push(w_ht(4'd3, 12'h5A3, 12'(nw)));
    rec("R3 trailer", 4'd2, 5'd0, {8'h0, 12'h5A3, 12'(nw - 1)});
    check("R4 matching trailer", out_frame_err, 0);

    // R8 / R11 time sweep
    for (int f = 0; f < 2; f++) begin
      fine_mode = f[0];
      for (int t = 4; t < 6; t++) begin
        for (int ch = 0; ch < 32; ch++) begin
          logic [18:0] d;
          logic [1:0]  fb;
          logic [20:0] et;
          d  = 19'((ch * 12345 + t * 777 + f) % 524288);
          fb = 2'(ch % 4);
          et = f[0] ? {d, fb} : {2'b00, d};
          push(w_dat(4'(t), 2'd0, fb, 5'(ch), d));
          rec("R8 time record", 4'd5, 5'(ch), {13'd0, d});
          check("R8 fine time", out_time, et);
          check("R11 reserved channel flag", out_chan_err, (ch >= 16));
        end
      end
    end
    fine_mode = 1'b0;

    // R9 samples and sums
    for (int m = 1; m < 4; m++) begin
      push(w_dat(4'd5, 2'(m), 2'd3, 5'd9, 19'h7ABCD));
      if (m == 3) rec("R9 sum", 4'd7, 5'd9, 32'h0007ABCD);
      else rec("R9 sample ignores 18:16", 4'd6, 5'd9, 32'h0000ABCD);
      check("R9 mode carried", out_mode, m);
    end

    // R10 timestamp pairing
    push(w_ts(2'd2, 5'd3, 1'b0, 16'hBEEF));
    check("R10 word1 no record", {out_valid, out_orphan}, 0);
    push(w_ts(2'd2, 5'd3, 1'b1, 16'h1234));
    rec("R10 stamp pair", 4'd8, 5'd3, 32'hBEEF1234);
    check("R10 stamp mode", out_mode, 2);
    push(w_ts(2'd1, 5'd3, 1'b1, 16'h5678));
    check("R10 repeat word2 orphan", {out_orphan, out_valid}, 2'b10);
    push(w_ts(2'd1, 5'd4, 1'b0, 16'h0F0F));
    push(w_ts(2'd1, 5'd5, 1'b1, 16'h0101));
    check("R10 channel mismatch orphan", {out_orphan, out_valid}, 2'b10);
    push(w_ts(2'd3, 5'd20, 1'b0, 16'h2222));
    check("R11 reserved flag without record", {out_chan_err, out_valid}, 2'b10);

    // R12 error words
    for (int b = 0; b < 15; b++) begin
      push({4'd6, 13'd0, 15'(1 << b)});
      rec("R12 error record", 4'd9, 5'd0, 32'd0);
      check("R12 flags", out_err_flags, (b == 14) ? 15'd0 : 15'(1 << b));
      check("R12 priority", out_prio_err, (b == 12 || b == 13));
    end
    push({4'd6, 13'h1FFF, 15'h7FFF});
    check("R12 all flags", {out_prio_err, out_err_flags}, {1'b1, 15'h3FFF});

    // R4 framing faults
    push(w_ht(4'd3, 12'h001, 12'h000));
    check("R4 trailer without header", {out_frame_err, out_kind}, {1'b1, 4'd2});
    push(w_ht(4'd2, 12'h010, 12'h000));
    nw = 0;
    push(32'h6000_0000); push(32'h7000_0000); push(32'h7000_0000);
    push(w_ht(4'd3, 12'h010, 12'd2));
    check("R4 wrong count", out_frame_err, 1);
    push(w_ht(4'd2, 12'h011, 12'h000));
    push(w_ht(4'd3, 12'h012, 12'd0));
    check("R4 wrong event number", out_frame_err, 1);
    push(w_ht(4'd2, 12'h020, 12'h000));
    push(w_ht(4'd2, 12'h021, 12'h0AB));
    rec("R4 header on open event record", 4'd1, 5'd0, 32'h000210AB);
    check("R4 header on open event", out_frame_err, 1);
    push(w_ht(4'd3, 12'h021, 12'd0));
    check("R4 second header reopened", out_frame_err, 0);

    // R1 reset clears pairing and framing
    push(w_cnt(4'd0, 9'd2, 16'h4444));
    push(w_ts(2'd1, 5'd6, 1'b0, 16'h5555));
    push(w_ht(4'd2, 12'h030, 12'h000));
    rst = 1'b1;
    idle();
    check("R1 ready low in reset", in_ready, 0);
    rst = 1'b0;
    push(w_cnt(4'd1, 9'd2, 16'h0000));
    check("R1 counter half forgotten", {out_orphan, out_valid}, 2'b10);
    push(w_ts(2'd1, 5'd6, 1'b1, 16'h0000));
    check("R1 stamp forgotten", {out_orphan, out_valid}, 2'b10);
    push(w_ht(4'd3, 12'h030, 12'd0));
    check("R1 event closed by reset", out_frame_err, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule